// File: doc/BRIEF.md
# Multi-Profile Waveform Memory Sequencer

This block drives the read address of a waveform memory. It holds eight profiles, and each profile describes one segment of that memory: a first address, a last address, and how many clock cycles each address is held. Once a sequence starts, the block plays profile 0's segment. Each time a segment reaches its last address, the block moves on to the next profile. This continues through a final profile that a 4-bit control code selects.

The control code also sets what happens after the final profile. A one-shot (burst) sequence stops there and raises a halted flag. A looping (continuous) sequence returns to profile 0 and runs again without end. Software writes profile settings and the control code into a pending copy. These have no effect until a single update strobe moves them into the active copy and restarts the sequence from profile 0. The block has no external profile-select pins and no per-profile mode field, so none can override the sequencing.

Top module: `wseq_top`

## Requirements
- R1: After reset, the address output is 0, the profile index is 0 and the halted flag is 0.
- R2: An update strobe copies the pending code and all pending profiles into the active set. On the next cycle the profile index is 0, the address equals the pending start address of profile 0, and halted is 0.
- R3: While running, each address is held for exactly the active profile's 16-bit interval in clock cycles. An interval of 0 behaves as 1.
- R4: Within a profile the address rises by one per step and wraps from 1023 to 0. A profile whose start equals its end holds that single address for one interval.
- R5: When a step is due at the current profile's end address and that profile is not the final one, the index increments. The address becomes the new profile's start address, and the new profile's interval then applies.
- R6: Codes 1 to 7 (burst) make profile N, where N is the code value, the final profile. A step due at its end address sets halted to 1 and freezes the address and the profile index until the next update strobe.
- R7: Codes 8 to 14 (continuous) make profile code−7 the final profile. A step due at its end address returns to profile 0 at profile 0's start address, and halted stays 0.
- R8: Codes 0 (sequencing off) and 15 (invalid) leave the block idle after an update. The address stays at profile 0's start address, the index stays at 0, and halted stays 0.
- R9: Writes to the pending code or to pending profiles have no effect on any output until an update strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prof_we | input | 1 | Write one pending profile |
| prof_sel | input | 3 | Index of the pending profile to write |
| prof_start | input | 10 | Pending start address |
| prof_end | input | 10 | Pending end address |
| prof_intv | input | 16 | Pending cycles per address step |
| code_we | input | 1 | Write the pending control code |
| code_in | input | 4 | Pending control code value |
| upd | input | 1 | Update strobe: commit pending settings and restart |
| addr | output | 10 | Current waveform memory address |
| prof | output | 3 | Active profile index |
| halted | output | 1 | Burst sequence has finished |

## Verification
On every cycle, the assertions check these properties: halted is only ever seen under a burst code and freezes the address. Steps inside a profile add exactly one. The index never passes the code's final profile. Idle codes keep the outputs still, and an update strobe always returns the block to profile 0 without halted.

The bench's cycle-level model is needed for the rest. It shows that each address is held for exactly its interval, including the zero-interval case, and that the next profile's own start address and interval take over at the hand-off. It also shows that a looping sequence lands back on profile 0's start address and that pending writes stay invisible until the strobe. Directed runs cover the wrap from 1023 to 0, single-address profiles and both idle codes. Seeded random runs mix codes, ranges and intervals, and add mid-run pending writes and restarts.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int ADDR_W_DEF = 10;
  localparam int INTV_W_DEF = 16;
  localparam int NPROF_DEF  = 8;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_HALT = 2'd2} seq_state_t;

  // one-shot codes: 1..7
  function automatic logic code_is_burst(input logic [3:0] c);
    return (c != 4'd0) && (c[3] == 1'b0);
  endfunction

  // looping codes: 8..14
  function automatic logic code_is_loop(input logic [3:0] c);
    return c[3] && (c != 4'hF);
  endfunction

  // index of the final profile for a running code
  function automatic logic [2:0] code_last(input logic [3:0] c);
    logic [3:0] t;
    if (code_is_burst(c))     t = c;
    else if (code_is_loop(c)) t = c - 4'd7;
    else                      t = 4'd0;
    return t[2:0];
  endfunction
endpackage

// File: rtl/wseq_bank.sv
module wseq_bank
  import wseq_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int INTV_W = INTV_W_DEF,
  parameter int NPROF  = NPROF_DEF,
  localparam int PW    = $clog2(NPROF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_idx,
  input  logic [ADDR_W-1:0] wr_start,
  input  logic [ADDR_W-1:0] wr_end,
  input  logic [INTV_W-1:0] wr_intv,
  input  logic              code_we,
  input  logic [3:0]        code_in,
  input  logic              commit,
  input  logic [PW-1:0]     cur_idx,
  input  logic [PW-1:0]     nxt_idx,
  output logic [ADDR_W-1:0] cur_end,
  output logic [INTV_W-1:0] cur_intv,
  output logic [ADDR_W-1:0] nxt_start,
  output logic [ADDR_W-1:0] pend0_start,
  output logic [3:0]        pend_code
);
  logic [ADDR_W-1:0] p_start [NPROF];
  logic [ADDR_W-1:0] p_end   [NPROF];
  logic [INTV_W-1:0] p_intv  [NPROF];
  logic [ADDR_W-1:0] a_start [NPROF];
  logic [ADDR_W-1:0] a_end   [NPROF];
  logic [INTV_W-1:0] a_intv  [NPROF];

  for (genvar g = 0; g < NPROF; g++) begin : g_prof
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_start[g] <= '0;
        p_end[g]   <= '0;
        p_intv[g]  <= '0;
        a_start[g] <= '0;
        a_end[g]   <= '0;
        a_intv[g]  <= '0;
      end else begin
        if (wr_en && (wr_idx == PW'(g))) begin
          p_start[g] <= wr_start;
          p_end[g]   <= wr_end;
          p_intv[g]  <= wr_intv;
        end
        if (commit) begin
          a_start[g] <= p_start[g];
          a_end[g]   <= p_end[g];
          a_intv[g]  <= p_intv[g];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pend_code <= 4'd0;
    else if (code_we) pend_code <= code_in;
  end

  assign cur_end     = a_end[cur_idx];
  assign cur_intv    = a_intv[cur_idx];
  assign nxt_start   = a_start[nxt_idx];
  assign pend0_start = p_start[0];
endmodule

// File: rtl/wseq_timer.sv
module wseq_timer
  import wseq_pkg::*;
#(
  parameter int INTV_W = INTV_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              en,
  input  logic [INTV_W-1:0] intv,
  output logic              tick
);
  logic [INTV_W-1:0] cnt;
  logic [INTV_W-1:0] lim;

  // zero interval behaves as one cycle per step
  function automatic logic [INTV_W-1:0] eff_limit(input logic [INTV_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign lim  = eff_limit(intv);
  assign tick = en && !restart && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (tick)         cnt <= '0;
    else if (en)           cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt <= lim);
  p_tick_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !tick) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
  import wseq_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int NPROF  = NPROF_DEF,
  localparam int PW    = $clog2(NPROF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [3:0]        pend_code,
  input  logic [ADDR_W-1:0] pend0_start,
  input  logic              tick,
  input  logic [ADDR_W-1:0] cur_end,
  input  logic [ADDR_W-1:0] nxt_start,
  output logic [PW-1:0]     nxt_idx,
  output logic              running,
  output logic [ADDR_W-1:0] addr,
  output logic [PW-1:0]     prof,
  output logic              halted
);
  seq_state_t state;
  logic [3:0] code_act;
  logic       at_end;
  logic       at_last;
  logic       step_in;
  logic       step_hop;

  assign running  = (state == ST_RUN);
  assign at_end   = (addr == cur_end);
  assign at_last  = (prof == PW'(code_last(code_act)));
  assign nxt_idx  = at_last ? '0 : prof + 1'b1;
  assign step_in  = running && tick && !at_end;
  assign step_hop = running && tick && at_end && !(at_last && code_is_burst(code_act));
  assign halted   = (state == ST_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      code_act <= 4'd0;
      prof     <= '0;
      addr     <= '0;
    end else if (upd) begin
      code_act <= pend_code;
      prof     <= '0;
      addr     <= pend0_start;
      state    <= (code_is_burst(pend_code) || code_is_loop(pend_code)) ? ST_RUN : ST_IDLE;
    end else if (step_in) begin
      addr <= addr + 1'b1;
    end else if (step_hop) begin
      prof <= nxt_idx;
      addr <= nxt_start;
    end else if (running && tick) begin
      state <= ST_HALT;
    end
  end

  p_halt_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> code_is_burst(code_act));
  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !upd) |=> halted && $stable(addr) && $stable(prof));
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_in && !upd) |=> addr == ADDR_W'($past(addr) + 1'b1));
  p_prof_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> prof <= PW'(code_last(code_act)));
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (prof == '0) && !halted);
  p_idle_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !upd) |=> $stable(addr) && $stable(prof) && !halted);
endmodule

// File: rtl/wseq_top.sv
module wseq_top
  import wseq_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int INTV_W = INTV_W_DEF,
  parameter int NPROF  = NPROF_DEF,
  localparam int PW    = $clog2(NPROF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prof_we,
  input  logic [PW-1:0]     prof_sel,
  input  logic [ADDR_W-1:0] prof_start,
  input  logic [ADDR_W-1:0] prof_end,
  input  logic [INTV_W-1:0] prof_intv,
  input  logic              code_we,
  input  logic [3:0]        code_in,
  input  logic              upd,
  output logic [ADDR_W-1:0] addr,
  output logic [PW-1:0]     prof,
  output logic              halted
);
  logic [ADDR_W-1:0] cur_end;
  logic [INTV_W-1:0] cur_intv;
  logic [ADDR_W-1:0] nxt_start;
  logic [ADDR_W-1:0] pend0_start;
  logic [3:0]        pend_code;
  logic [PW-1:0]     nxt_idx;
  logic              running;
  logic              tick;

  wseq_bank #(.ADDR_W(ADDR_W), .INTV_W(INTV_W), .NPROF(NPROF)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(prof_we), .wr_idx(prof_sel), .wr_start(prof_start),
    .wr_end(prof_end), .wr_intv(prof_intv),
    .code_we(code_we), .code_in(code_in), .commit(upd),
    .cur_idx(prof), .nxt_idx(nxt_idx),
    .cur_end(cur_end), .cur_intv(cur_intv), .nxt_start(nxt_start),
    .pend0_start(pend0_start), .pend_code(pend_code)
  );

  wseq_timer #(.INTV_W(INTV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(upd), .en(running),
    .intv(cur_intv), .tick(tick)
  );

  wseq_ctrl #(.ADDR_W(ADDR_W), .NPROF(NPROF)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .upd(upd),
    .pend_code(pend_code), .pend0_start(pend0_start),
    .tick(tick), .cur_end(cur_end), .nxt_start(nxt_start),
    .nxt_idx(nxt_idx), .running(running),
    .addr(addr), .prof(prof), .halted(halted)
  );

  p_reset_out_r1: assert property (@(posedge clk)
    !rst_n |=> (addr == '0) && (prof == '0) && !halted);
endmodule

// File: tb/wseq_top_tb.sv
module wseq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prof_we = 1'b0;
  logic [2:0]  prof_sel = '0;
  logic [9:0]  prof_start = '0;
  logic [9:0]  prof_end = '0;
  logic [15:0] prof_intv = '0;
  logic        code_we = 1'b0;
  logic [3:0]  code_in = '0;
  logic        upd = 1'b0;
  logic [9:0]  addr;
  logic [2:0]  prof;
  logic        halted;

  wseq_top u_dut (.*);

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit live = 1'b0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  int pst[8], pen[8], pin[8], ast[8], aen[8], ain[8];
  int pcode = 0, acode = 0;
  int m_st = 0, m_prof = 0, m_addr = 0, m_left = 0;

  function automatic int b_final(int c);
    if (c >= 1 && c <= 7) return c;
    if (c >= 8 && c <= 14) return c - 7;
    return -1;
  endfunction

  function automatic int b_hold(int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        pst[i] = 0; pen[i] = 0; pin[i] = 0; ast[i] = 0; aen[i] = 0; ain[i] = 0;
      end
      pcode = 0; acode = 0; m_st = 0; m_prof = 0; m_addr = 0; m_left = 0;
    end else begin
      if (upd) begin
        for (int i = 0; i < 8; i++) begin
          ast[i] = pst[i]; aen[i] = pen[i]; ain[i] = pin[i];
        end
        acode = pcode;
        m_prof = 0;
        m_addr = ast[0];
        m_left = b_hold(ain[0]);
        m_st = (b_final(acode) >= 0) ? 1 : 0;
      end else if (m_st == 1) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          if (m_addr != aen[m_prof]) begin
            m_addr = (m_addr + 1) % 1024;
          end else if (m_prof != b_final(acode)) begin
            m_prof = m_prof + 1;
            m_addr = ast[m_prof];
          end else if (acode >= 8) begin
            m_prof = 0;
            m_addr = ast[0];
          end else begin
            m_st = 2;
          end
          m_left = b_hold(ain[m_prof]);
        end
      end
      if (prof_we) begin
        pst[prof_sel] = prof_start; pen[prof_sel] = prof_end; pin[prof_sel] = prof_intv;
      end
      if (code_we) pcode = code_in;
    end
  end

  task automatic check(string t, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      check({tag, " addr"}, addr, m_addr);
      check({tag, " prof"}, prof, m_prof);
      check({tag, " halted"}, halted, (m_st == 2) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr_prof(int i, int s, int e, int iv);
    @(negedge clk);
    prof_we = 1'b1; prof_sel = i[2:0]; prof_start = s[9:0]; prof_end = e[9:0]; prof_intv = iv[15:0];
    @(negedge clk);
    prof_we = 1'b0;
  endtask

  task automatic wr_code(int c);
    @(negedge clk);
    code_we = 1'b1; code_in = c[3:0];
    @(negedge clk);
    code_we = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    check("R1 reset addr", addr, 0);
    check("R1 reset prof", prof, 0);
    check("R1 reset halted", halted, 0);
    live = 1'b1;

    // R9: pending writes alone change nothing
    tag = "R9";
    wr_prof(0, 300, 302, 1);
    wr_code(3);
    idle(8);
    check("R9 addr untouched", addr, 0);

    // R2/R3/R4/R5/R6: burst over three profiles, wrap and single-address profile
    tag = "R6 burst";
    wr_prof(0, 10, 12, 2);
    wr_prof(1, 100, 100, 0);
    wr_prof(2, 1022, 1, 3);
    wr_code(2);
    strobe();
    check("R2 start addr", addr, 10);
    check("R2 start prof", prof, 0);
    idle(1);
    check("R3 held for interval", addr, 10);
    idle(1);
    check("R4 plus one", addr, 11);
    idle(4);
    check("R5 next start", addr, 100);
    check("R5 next prof", prof, 1);
    idle(1);
    check("R4 single address", addr, 1022);
    idle(30);
    check("R6 halted", halted, 1);
    check("R6 frozen addr", addr, 1);
    check("R6 frozen prof", prof, 2);
    // R9 during halt
    wr_prof(0, 500, 501, 1);
    wr_code(9);
    idle(5);
    check("R9 halted kept", halted, 1);

    // R7: loop over profiles 0..2, then restart from profile 0
    tag = "R7 loop";
    strobe();
    check("R2 restart addr", addr, 500);
    check("R2 halted cleared", halted, 0);
    idle(60);

    // R8: idle codes
    tag = "R8 idle";
    wr_code(15);
    strobe();
    idle(12);
    check("R8 code15 addr", addr, 500);
    check("R8 code15 prof", prof, 0);
    wr_code(0);
    strobe();
    idle(12);
    check("R8 code0 halted", halted, 0);

    // random mix: R3 R4 R5 R6 R7 R9
    for (int it = 0; it < 40; it++) begin
      tag = "R3/R4/R5/R6/R7 random";
      for (int p = 0; p < 8; p++) begin
        int s = $urandom_range(0, 1023);
        wr_prof(p, s, (s + $urandom_range(0, 4)) % 1024, $urandom_range(0, 3));
      end
      wr_code($urandom_range(0, 15));
      strobe();
      idle($urandom_range(20, 90));
      if ($urandom_range(0, 2) == 0) begin
        tag = "R9 random";
        wr_prof($urandom_range(0, 7), $urandom_range(0, 1023), $urandom_range(0, 1023), 2);
        wr_code($urandom_range(0, 15));
        idle(20);
      end
    end

    live = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule